// File: doc/BRIEF.md
# Periodic Waveform Sequencer for a Serial 12-bit DAC

This block produces a steady stream of samples and sends each one to a write-only 12-bit serial DAC over an SPI-style link. On a fixed interval of system clocks it picks the next sample value and packs it under a fixed 4-bit control prefix into a 16-bit frame. It then shifts the frame out MSB first with active-low chip select, a serial clock at one quarter of the system clock, and serial data. The DAC's load input is held low, so the converter updates its output as soon as chip select returns high.

A 2-bit mode input selects the shape. In ramp mode the value counts up through every 12-bit code and wraps. In triangle mode the value bounces between 0 and 63. In level mode the value is held at mid-scale. The mode is sampled only at the sample strobe. When the mode there differs from the mode of the previous sample, the counting shapes restart from 0 going upward.

With the default 50 MHz clock the block sends 100 k samples per second. Each frame takes 1.28 µs, and a full ramp repeats every 40.96 ms.

Top module: `wave_dac_seq`

## Requirements
- R1: While reset is asserted and after it is released until the first frame, chip select is high, the serial clock and serial data are low, and busy is low. The load output is low at all times.
- R2: Each frame has exactly 16 rising serial-clock edges, all within one chip-select-low window that lasts 64 system clocks (serial clock = system clock / 4).
- R3: Read MSB first at the rising serial-clock edges, frame bits 15..12 are binary 0011 and bits 11..0 are the sample value.
- R4: Serial data changes only while the serial clock is low, so it is stable across every rising edge. The serial clock stays low whenever chip select is high.
- R5: Successive frames begin (chip select falling) exactly INTERVAL = 500 system clocks apart.
- R6: Mode code 0 (ramp) sends 0, 1, 2, … increasing by one per frame, modulo 4096. The first frame after reset is 0.
- R7: Mode code 1 (triangle) sends 0, 1, …, 63, 62, …, 1, 0, 1, … Each turning value appears once per turn, giving a period of 126 frames.
- R8: Mode codes 2 and 3 (level) send 2048 in every frame.
- R9: A mode change affects only frames whose sample strobe comes after the change. The first frame in a new ramp or triangle mode carries 0, and the triangle starts upward.
- R10: Busy is high in exactly the cycles in which chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (50 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Waveform select: 0 ramp, 1 triangle, 2/3 level |
| dac_cs_n_o | output | 1 | Active-low DAC chip select |
| dac_sck_o | output | 1 | Serial clock, idles low |
| dac_sdi_o | output | 1 | Serial data, MSB first |
| dac_ldac_n_o | output | 1 | DAC load input, tied low |
| busy_o | output | 1 | High while a frame is being shifted |

## Verification
The bench rebuilds every frame from the pins at the rising serial-clock edges. It checks the bit count, the prefix, the value and the frame spacing, so a divider off by one shows up as a wrong chip-select width or a missing bit, and a frame shifted one bit early shows up as a broken prefix. The triangle run covers both the top and bottom turns; a design that repeated 63 or 0, or overshot to 64, would break the 126-frame pattern. Mode switches go into the gap between frames. A design that carried the old value across a switch would send 40 instead of 0 on entering the triangle, and a design that applied the mode mid-frame would corrupt the frame in flight. A separate watch on serial data while the serial clock is high catches data that moves on the wrong edge.

// File: rtl/wds_pkg.sv
package wds_pkg;

   typedef enum logic [1:0] {
      WM_RAMP  = 2'd0,
      WM_TRI   = 2'd1,
      WM_LVL   = 2'd2,
      WM_LVL_B = 2'd3
   } wave_mode_e;

endpackage

// File: rtl/wds_tick.sv
// Sample-rate strobe: count-down counter reloaded on zero.
module wds_tick #(
   parameter int INTERVAL = 500
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic strobe_o
);
   localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
   localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= RELOAD;
         strobe_o <= 1'b0;
      end else if (cnt_q == '0) begin
         cnt_q    <= RELOAD;
         strobe_o <= 1'b1;
      end else begin
         cnt_q    <= cnt_q - 1'b1;
         strobe_o <= 1'b0;
      end
   end
endmodule

// File: rtl/wds_shape.sv
// Sample value generator: ramp, bouncing triangle or fixed level.
module wds_shape
   import wds_pkg::*;
#(
   parameter int DW       = 12,
   parameter int TRI_MAX  = 63,
   parameter int MID_CODE = 2048
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          strobe_i,
   input  wave_mode_e    mode_i,
   output logic [DW-1:0] value_o
);
   localparam logic [DW-1:0] TRI_LIM = DW'(TRI_MAX);
   localparam logic [DW-1:0] LVL_VAL = DW'(MID_CODE);

   logic [DW-1:0] val_q, base, nxt;
   logic          dn_q, dn_base, nxt_dn;
   wave_mode_e    mode_q;
   logic          restart;

   always_comb begin
      restart = (mode_i != mode_q);
      base    = restart ? '0 : val_q;
      dn_base = restart ? 1'b0 : dn_q;
      value_o = base;
      nxt     = base;
      nxt_dn  = dn_base;
      unique case (mode_i)
         WM_RAMP: begin
            nxt    = base + 1'b1;
            nxt_dn = 1'b0;
         end
         WM_TRI: begin
            if (!dn_base) begin
               if (base >= TRI_LIM) begin
                  nxt    = base - 1'b1;
                  nxt_dn = 1'b1;
               end else begin
                  nxt    = base + 1'b1;
               end
            end else begin
               if (base == '0) begin
                  nxt    = base + 1'b1;
                  nxt_dn = 1'b0;
               end else begin
                  nxt    = base - 1'b1;
               end
            end
         end
         default: begin
            value_o = LVL_VAL;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         val_q  <= '0;
         dn_q   <= 1'b0;
         mode_q <= WM_RAMP;
      end else if (strobe_i) begin
         val_q  <= nxt;
         dn_q   <= nxt_dn;
         mode_q <= mode_i;
      end
   end
endmodule

// File: rtl/wds_spi_tx.sv
// Frame shifter: MSB first, SCK = clk / SCK_DIV, data moves with SCK fall.
module wds_spi_tx #(
   parameter int FW      = 16,
   parameter int SCK_DIV = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [FW-1:0] frame_i,
   output logic          cs_n_o,
   output logic          sck_o,
   output logic          sdi_o,
   output logic          busy_o
);
   localparam int PW = $clog2(SCK_DIV);
   localparam int BW = $clog2(FW);
   localparam logic [PW-1:0] PH_LAST  = PW'(SCK_DIV - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(FW - 1);

   logic          active_q;
   logic [PW-1:0] ph_q;
   logic [BW-1:0] bit_q;
   logic [FW-1:0] sr_q;
   logic          sck_hi;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         ph_q     <= '0;
         bit_q    <= '0;
         sr_q     <= '0;
      end else if (!active_q) begin
         if (load_i) begin
            active_q <= 1'b1;
            ph_q     <= '0;
            bit_q    <= '0;
            sr_q     <= frame_i;
         end
      end else if (ph_q == PH_LAST) begin
         ph_q <= '0;
         if (bit_q == BIT_LAST) begin
            active_q <= 1'b0;
            sr_q     <= '0;
         end else begin
            bit_q <= bit_q + 1'b1;
            sr_q  <= {sr_q[FW-2:0], 1'b0};
         end
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   generate
      if ((SCK_DIV & (SCK_DIV - 1)) == 0) begin : g_pow2
         assign sck_hi = ph_q[PW-1];
      end else begin : g_cmp
         assign sck_hi = (ph_q >= PW'(SCK_DIV / 2));
      end
   endgenerate

   assign cs_n_o = ~active_q;
   assign busy_o = active_q;
   assign sck_o  = active_q & sck_hi;
   assign sdi_o  = active_q & sr_q[FW-1];
endmodule

// File: rtl/wave_dac_seq.sv
module wave_dac_seq
   import wds_pkg::*;
#(
   parameter int                 INTERVAL  = 500,
   parameter int                 DW        = 12,
   parameter int                 CTRL_W    = 4,
   parameter logic [CTRL_W-1:0]  CTRL_CODE = 4'b0011,
   parameter int                 SCK_DIV   = 4,
   parameter int                 TRI_MAX   = 63,
   parameter int                 MID_CODE  = 2048
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] mode_i,
   output logic       dac_cs_n_o,
   output logic       dac_sck_o,
   output logic       dac_sdi_o,
   output logic       dac_ldac_n_o,
   output logic       busy_o
);
   localparam int FW = CTRL_W + DW;

   generate
      if (SCK_DIV < 2 || (SCK_DIV % 2) != 0) begin : g_bad_div
         $error("SCK_DIV must be even and at least 2");
      end
      if (INTERVAL <= FW * SCK_DIV) begin : g_bad_interval
         $error("INTERVAL must exceed one frame length");
      end
      if (TRI_MAX < 1 || TRI_MAX >= (1 << DW) || MID_CODE >= (1 << DW)) begin : g_bad_code
         $error("TRI_MAX and MID_CODE must fit the data width");
      end
      if (CTRL_W < 1 || DW < 2) begin : g_bad_width
         $error("frame field widths too small");
      end
   endgenerate

   logic          strobe;
   logic [DW-1:0] value;

   wds_tick #(.INTERVAL(INTERVAL)) tick_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_o (strobe)
   );

   wds_shape #(.DW(DW), .TRI_MAX(TRI_MAX), .MID_CODE(MID_CODE)) shape_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe),
      .mode_i   (wave_mode_e'(mode_i)),
      .value_o  (value)
   );

   wds_spi_tx #(.FW(FW), .SCK_DIV(SCK_DIV)) tx_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (strobe),
      .frame_i ({CTRL_CODE, value}),
      .cs_n_o  (dac_cs_n_o),
      .sck_o   (dac_sck_o),
      .sdi_o   (dac_sdi_o),
      .busy_o  (busy_o)
   );

   assign dac_ldac_n_o = 1'b0;
endmodule

// File: rtl/wds_chk.sv
module wds_chk #(
   parameter int INTERVAL = 500,
   parameter int FW       = 16,
   parameter int SCK_DIV  = 4
) (
   input logic clk_i,
   input logic rst_ni,
   input logic cs_n,
   input logic sck,
   input logic sdi,
   input logic ldac_n,
   input logic busy
);
   localparam int GW = $clog2(INTERVAL + 2) + 1;
   localparam int LW = $clog2(FW * SCK_DIV + 2) + 1;
   localparam logic [GW-1:0] GAP_MAX = {GW{1'b1}};
   localparam logic [LW-1:0] LOW_MAX = {LW{1'b1}};

   logic [GW-1:0] gap_q;
   logic [LW-1:0] low_q;
   logic          cs_prev_q, seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gap_q     <= '0;
         low_q     <= '0;
         cs_prev_q <= 1'b1;
         seen_q    <= 1'b0;
      end else begin
         cs_prev_q <= cs_n;
         if (!cs_n && cs_prev_q) begin
            gap_q  <= 1;
            seen_q <= 1'b1;
         end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
         end
         if (cs_n) low_q <= '0;
         else if (low_q != LOW_MAX) low_q <= low_q + 1'b1;
      end
   end

   assert_ldac_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ldac_n);

   assert_cs_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cs_n && !cs_prev_q) |-> (low_q == LW'(FW * SCK_DIV)));

   assert_sck_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_n |-> !sck);

   assert_sdi_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sck) |-> $stable(sdi));

   assert_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cs_n && cs_prev_q && seen_q) |-> (gap_q == GW'(INTERVAL)));

   assert_busy_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy == !cs_n);
endmodule

bind wave_dac_seq wds_chk #(.INTERVAL(INTERVAL), .FW(FW), .SCK_DIV(SCK_DIV)) chk_i (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .cs_n   (dac_cs_n_o),
   .sck    (dac_sck_o),
   .sdi    (dac_sdi_o),
   .ldac_n (dac_ldac_n_o),
   .busy   (busy_o)
);

// File: tb/wave_dac_seq_tb_top.sv
module wave_dac_seq_tb_top;
   localparam int INTERVAL = 500;
   localparam int MAXF     = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       cs_n, sck, sdi, ldac_n, busy;

   always #5 clk = ~clk;

   wave_dac_seq dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .mode_i       (mode),
      .dac_cs_n_o   (cs_n),
      .dac_sck_o    (sck),
      .dac_sdi_o    (sdi),
      .dac_ldac_n_o (ldac_n),
      .busy_o       (busy)
   );

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   bit timeout = 1'b0;

   // frame monitor, sampled on the falling system clock edge
   int          nfr = 0;
   logic [15:0] f_word [MAXF];
   int          f_bits [MAXF];
   int          f_low  [MAXF];
   int          f_start[MAXF];
   logic [15:0] word;
   int          nbits, lowc, start_cyc;
   logic        prev_cs = 1'b1, prev_sck = 1'b0, prev_sdi = 1'b0;
   int          busy_bad = 0, idle_bad = 0, sdi_bad = 0, ldac_bad = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (busy !== !cs_n) busy_bad++;
         if (cs_n && sck) idle_bad++;
         if (sck && sdi !== prev_sdi) sdi_bad++;
         if (ldac_n !== 1'b0) ldac_bad++;
         if (!cs_n && prev_cs) begin
            start_cyc = cyc; nbits = 0; word = '0; lowc = 0;
         end
         if (!cs_n) begin
            lowc++;
            if (sck && !prev_sck) begin
               word = {word[14:0], sdi};
               nbits++;
            end
         end
         if (cs_n && !prev_cs && nfr < MAXF) begin
            f_word[nfr]  = word;
            f_bits[nfr]  = nbits;
            f_low[nfr]   = lowc;
            f_start[nfr] = start_cyc;
            nfr++;
         end
      end
      prev_cs  = cs_n;
      prev_sck = sck;
      prev_sdi = sdi;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_frames(input int target);
      while (nfr < target && !timeout) @(negedge clk);
   endtask

   // check frames [i0, i0+n) against expected values from kind
   // kind 0: ramp k, 1: triangle, 2: level
   task automatic check_frames(input int i0, input int n, input int kind);
      for (int k = 0; k < n; k++) begin
         int i = i0 + k;
         int m = k % 126;
         int exp;
         case (kind)
            0:       exp = k % 4096;
            1:       exp = (m <= 63) ? m : 126 - m;
            default: exp = 2048;
         endcase
         check(f_bits[i] == 16, "R2 bits per frame", f_bits[i], 16);
         check(f_low[i] == 64, "R2 cs low cycles", f_low[i], 64);
         check(f_word[i][15:12] == 4'b0011, "R3 control prefix", int'(f_word[i][15:12]), 3);
         if (kind == 0)      check(int'(f_word[i][11:0]) == exp, "R6 ramp value", int'(f_word[i][11:0]), exp);
         else if (kind == 1) check(int'(f_word[i][11:0]) == exp, "R7 triangle value", int'(f_word[i][11:0]), exp);
         else                check(int'(f_word[i][11:0]) == exp, "R8 level value", int'(f_word[i][11:0]), exp);
         if (i > 0)
            check(f_start[i] - f_start[i-1] == INTERVAL, "R5 frame spacing",
                  f_start[i] - f_start[i-1], INTERVAL);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(cs_n == 1'b1, "R1 reset cs_n", int'(cs_n), 1);
      check(sck == 1'b0, "R1 reset sck", int'(sck), 0);
      check(sdi == 1'b0, "R1 reset sdi", int'(sdi), 0);
      check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
      check(ldac_n == 1'b0, "R1 reset ldac_n", int'(ldac_n), 0);
      rst_n = 1'b1;
      repeat (100) @(negedge clk);
      check(cs_n == 1'b1 && busy == 1'b0 && nfr == 0, "R1 idle before first frame",
            int'(cs_n), 1);
   endtask

   task automatic t_ramp();
      int i0 = nfr;
      wait_frames(i0 + 40);
      check_frames(i0, 40, 0);
   endtask

   task automatic t_tri();
      int i0 = nfr;
      mode = 2'd1;
      wait_frames(i0 + 130);
      check_frames(i0, 130, 1);
   endtask

   task automatic t_level();
      int i0 = nfr;
      mode = 2'd2;
      wait_frames(i0 + 4);
      check_frames(i0, 4, 2);
      i0 = nfr;
      mode = 2'd3;
      wait_frames(i0 + 3);
      check_frames(i0, 3, 2);
   endtask

   task automatic t_switch();
      int i0 = nfr;
      mode = 2'd0;
      wait_frames(i0 + 5);
      check(int'(f_word[i0][11:0]) == 0, "R9 ramp restarts at 0", int'(f_word[i0][11:0]), 0);
      check_frames(i0, 5, 0);
      i0 = nfr;
      mode = 2'd1;
      wait_frames(i0 + 4);
      check(int'(f_word[i0][11:0]) == 0, "R9 triangle restarts at 0", int'(f_word[i0][11:0]), 0);
      check_frames(i0, 4, 1);
   endtask

   task automatic t_pins();
      check(busy_bad == 0, "R10 busy tracks cs_n", busy_bad, 0);
      check(idle_bad == 0, "R4 sck idle low", idle_bad, 0);
      check(sdi_bad == 0, "R4 sdi stable while sck high", sdi_bad, 0);
      check(ldac_bad == 0, "R1 ldac_n held low", ldac_bad, 0);
   endtask

   initial begin
      int wd = 0;
      while (wd < 150000 && nfr < 186) begin
         @(negedge clk);
         wd++;
      end
      if (nfr < 186) timeout = 1'b1;
   end

   initial begin
      t_reset();
      t_ramp();
      t_tri();
      t_level();
      t_switch();
      t_pins();
      if (timeout) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: frames %0d expected %0d", nfr, 186);
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule